// File: doc/BRIEF.md
# Descriptor-Chained Copy Channel Register Set

This block is the software-visible control and status register set of one copy channel that walks a linked list of descriptors in memory. Software writes the address of the first descriptor into a next-descriptor register and sets an enable bit. The channel then takes that address as its current descriptor, signals a fetch, and reports itself busy. The engine reports each finished descriptor on a descriptor-advance input, along with the link field it read from that descriptor. A non-zero link moves the channel to the next descriptor. A zero link ends the chain.

When a chain has ended or the channel is idle, software can extend the work by loading a new next-descriptor address and setting an append bit. The channel then fetches again from the next-descriptor register, and the append bit clears itself. Completion and error events are kept as sticky flags in a status word. Software clears each flag by writing a one to its position. The OR of all the flags drives an interrupt line.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every register reads 0, `chan_busy` is 0 and `irq` is 0.
- R2: Offset 0x10 (next descriptor) reads back what was written. Offset 0x0C (current descriptor) ignores writes. Any offset other than 0x00, 0x04, 0x0C and 0x10 reads 0.
- R3: A write to offset 0x00 with bit 0 set, made while the channel is disabled, has these effects. `fetch_go` is 1 in that cycle. From the next cycle the channel is busy, and the current descriptor holds the value the next-descriptor register held.
- R4: `eng_adv` with a non-zero `eng_link` while the channel is busy has these effects. The current descriptor becomes `eng_link`, the channel stays busy, and status bit 9 (end of transfer) is set.
- R5: `eng_adv` with `eng_link` equal to 0 while the channel is busy sets status bits 9 and 8 (end of chain), and the channel is no longer busy from the next cycle.
- R6: Control bit 1 (append) written while the channel is enabled is held until the channel is not busy. The channel then loads the current descriptor from the next-descriptor register and becomes busy, and bit 1 reads 0 from the following cycle. An append bit set in the same write that enables the channel is dropped.
- R7: A write to offset 0x00 with bit 0 clear stops the channel (not busy from the next cycle) and discards any pending append. An append written while the channel is disabled is dropped.
- R8: `eng_err[0]`, `eng_err[1]`, `eng_err[2]` and `eng_err[3]` set status bits 1, 2, 3 and 5 respectively.
- R9: A write to offset 0x04 clears each of status bits 1, 2, 3, 5, 8 and 9 where the data has a 1 and leaves the rest. Status bit 10 always reads the busy state.
- R10: When an event sets a flag in the same cycle as a write-one-to-clear of that flag, the flag ends up set.
- R11: `irq` is 1 exactly when at least one of status bits 1, 2, 3, 5, 8 or 9 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, valid in the cycle `reg_rd` is high, 0 otherwise |
| eng_adv | input | 1 | Engine finished the current descriptor |
| eng_link | input | 32 | Link field of the finished descriptor (0 ends the chain) |
| eng_err | input | 4 | Error events from the engine, one cycle each |
| fetch_go | output | 1 | Pulse: the channel takes the next-descriptor address |
| cur_desc | output | 32 | Address of the descriptor being processed |
| chan_busy | output | 1 | Channel is running a chain |
| irq | output | 1 | OR of all sticky status flags |

## Verification
The chain walk is driven along a directed path. It starts from idle, advances with a non-zero link, and then hits a zero link while an append is already pending. This path separates an immediate refetch from a stop at chain end, and shows the one-cycle not-busy gap between them. Separate sequences cover a disable with an append pending, an append written while disabled, and an append written in the enabling write, so that each way an append can be dropped is seen on the control readback.

The status flags are then exercised by random error-event vectors, each coinciding with a random clear mask in the same cycle. This shows whether set and clear are ordered correctly per bit and whether `irq` follows the OR. One directed case puts a set and a clear on the same bit in the same cycle.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    // register offsets (software visible)
    localparam int OFS_CTRL = 'h00;
    localparam int OFS_STAT = 'h04;
    localparam int OFS_CUR  = 'h0C;
    localparam int OFS_NEXT = 'h10;

    // control bit positions
    localparam int CTL_EN     = 0;
    localparam int CTL_APPEND = 1;

    // status: busy position and sticky flag table
    localparam int ST_BUSY   = 10;
    localparam int NUM_ERR   = 4;
    localparam int NUM_FLAGS = NUM_ERR + 2;
    localparam int FLAG_EOC  = NUM_ERR;
    localparam int FLAG_EOT  = NUM_ERR + 1;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_RUN  = 2'd1,
        CH_DONE = 2'd2
    } chan_state_e;

    typedef struct packed {
        logic en;
        logic append;
    } ctrl_t;

    typedef struct packed {
        logic wr_ctrl;
        logic wr_stat;
        logic wr_next;
    } wsel_t;

    // status word bit position of sticky flag idx
    function automatic int flag_bit(input int idx);
        case (idx)
            0:       return 1;
            1:       return 2;
            2:       return 3;
            3:       return 5;
            4:       return 8;
            default: return 9;
        endcase
    endfunction

endpackage

// File: rtl/dcr_chan_ctrl.sv
module dcr_chan_ctrl
    import dcr_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_ctrl,
    input  logic          wr_next,
    input  logic [DW-1:0] wdata,
    input  logic          adv,
    input  logic [DW-1:0] link,
    output ctrl_t         ctrl,
    output logic          busy,
    output logic          load,
    output logic          ev_eot,
    output logic          ev_eoc,
    output logic [DW-1:0] cur,
    output logic [DW-1:0] nxt
);

    ctrl_t         ctrl_q;
    chan_state_e   state_q;
    logic [DW-1:0] cur_q;
    logic [DW-1:0] nxt_q;

    logic stop_wr;
    logic start;
    logic accept;
    logic run;

    always_comb begin
        run     = (state_q == CH_RUN);
        stop_wr = wr_ctrl && !wdata[CTL_EN];
        start   = wr_ctrl && wdata[CTL_EN] && !ctrl_q.en;
        accept  = ctrl_q.append && ctrl_q.en && !run && !stop_wr;
        load    = start || accept;
        ev_eot  = adv && run;
        ev_eoc  = adv && run && (link == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            state_q <= CH_IDLE;
            cur_q   <= '0;
            nxt_q   <= '0;
        end else begin
            if (wr_next) begin
                nxt_q <= wdata;
            end
            if (stop_wr) begin
                ctrl_q  <= '0;
                state_q <= CH_IDLE;
            end else begin
                if (wr_ctrl) begin
                    ctrl_q.en <= 1'b1;
                end
                if (accept) begin
                    ctrl_q.append <= 1'b0;
                end else if (wr_ctrl && ctrl_q.en && wdata[CTL_APPEND]) begin
                    ctrl_q.append <= 1'b1;
                end
                if (load) begin
                    state_q <= CH_RUN;
                    cur_q   <= nxt_q;
                end else if (adv && run) begin
                    if (link == '0) begin
                        state_q <= CH_DONE;
                    end else begin
                        cur_q <= link;
                    end
                end
            end
        end
    end

    assign ctrl = ctrl_q;
    assign busy = run;
    assign cur  = cur_q;
    assign nxt  = nxt_q;

endmodule

// File: rtl/dcr_flags.sv
module dcr_flags
    import dcr_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NF = NUM_FLAGS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NF-1:0] set,
    input  logic          wr_stat,
    input  logic [DW-1:0] wdata,
    output logic [NF-1:0] flags,
    output logic          irq
);

    logic [NF-1:0] flags_q;

    for (genvar i = 0; i < NF; i++) begin : g_flag
        localparam int POS = flag_bit(i);
        logic clr;
        assign clr = wr_stat && wdata[POS];
        always_ff @(posedge clk) begin
            if (rst) begin
                flags_q[i] <= 1'b0;
            end else if (set[i]) begin
                flags_q[i] <= 1'b1;
            end else if (clr) begin
                flags_q[i] <= 1'b0;
            end
        end
    end

    assign flags = flags_q;
    assign irq   = |flags_q;

endmodule

// File: rtl/dcr_rdmux.sv
module dcr_rdmux
    import dcr_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int NF = NUM_FLAGS
) (
    input  logic          rd,
    input  logic [AW-1:0] addr,
    input  ctrl_t         ctrl,
    input  logic          busy,
    input  logic [NF-1:0] flags,
    input  logic [DW-1:0] cur,
    input  logic [DW-1:0] nxt,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] stat_w;
    logic [DW-1:0] ctrl_w;

    always_comb begin
        stat_w          = '0;
        stat_w[ST_BUSY] = busy;
        for (int i = 0; i < NF; i++) begin
            stat_w[flag_bit(i)] = flags[i];
        end
        ctrl_w             = '0;
        ctrl_w[CTL_EN]     = ctrl.en;
        ctrl_w[CTL_APPEND] = ctrl.append;
    end

    always_comb begin
        rdata = '0;
        if (rd) begin
            case (addr)
                AW'(OFS_CTRL): rdata = ctrl_w;
                AW'(OFS_STAT): rdata = stat_w;
                AW'(OFS_CUR):  rdata = cur;
                AW'(OFS_NEXT): rdata = nxt;
                default:       rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dcr_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int NE = NUM_ERR
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    input  logic          reg_wr,
    input  logic          reg_rd,
    output logic [DW-1:0] reg_rdata,
    input  logic          eng_adv,
    input  logic [DW-1:0] eng_link,
    input  logic [NE-1:0] eng_err,
    output logic          fetch_go,
    output logic [DW-1:0] cur_desc,
    output logic          chan_busy,
    output logic          irq
);

    localparam int NF = NE + 2;

    wsel_t         wsel;
    ctrl_t         ctrl;
    logic          ev_eot;
    logic          ev_eoc;
    logic [DW-1:0] next_q;
    logic [NF-1:0] flag_set;
    logic [NF-1:0] flags;

    always_comb begin
        wsel.wr_ctrl = reg_wr && (reg_addr == AW'(OFS_CTRL));
        wsel.wr_stat = reg_wr && (reg_addr == AW'(OFS_STAT));
        wsel.wr_next = reg_wr && (reg_addr == AW'(OFS_NEXT));
    end

    dcr_chan_ctrl #(.DW(DW)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (wsel.wr_ctrl),
        .wr_next (wsel.wr_next),
        .wdata   (reg_wdata),
        .adv     (eng_adv),
        .link    (eng_link),
        .ctrl    (ctrl),
        .busy    (chan_busy),
        .load    (fetch_go),
        .ev_eot  (ev_eot),
        .ev_eoc  (ev_eoc),
        .cur     (cur_desc),
        .nxt     (next_q)
    );

    assign flag_set = {ev_eot, ev_eoc, eng_err};

    dcr_flags #(.DW(DW), .NF(NF)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set     (flag_set),
        .wr_stat (wsel.wr_stat),
        .wdata   (reg_wdata),
        .flags   (flags),
        .irq     (irq)
    );

    dcr_rdmux #(.DW(DW), .AW(AW), .NF(NF)) u_rdmux (
        .rd    (reg_rd),
        .addr  (reg_addr),
        .ctrl  (ctrl),
        .busy  (chan_busy),
        .flags (flags),
        .cur   (cur_desc),
        .nxt   (next_q),
        .rdata (reg_rdata)
    );

endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk
    import dcr_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int NE = NUM_ERR
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [DW-1:0] reg_rdata,
    input logic          eng_adv,
    input logic [DW-1:0] eng_link,
    input logic [NE-1:0] eng_err,
    input logic          fetch_go,
    input logic [DW-1:0] cur_desc,
    input logic          chan_busy,
    input logic          irq,
    input logic [DW-1:0] next_desc,
    input logic          append_q,
    input logic          en_q
);

    logic ctrl_wr;
    logic stop_wr;
    assign ctrl_wr = reg_wr && (reg_addr == AW'(OFS_CTRL));
    assign stop_wr = ctrl_wr && !reg_wdata[CTL_EN];

    assert_fetch_busy_R3: assert property (@(posedge clk) disable iff (rst)
        fetch_go |=> chan_busy && (cur_desc == $past(next_desc)));

    assert_adv_link_R4: assert property (@(posedge clk) disable iff (rst)
        (chan_busy && eng_adv && (eng_link != '0) && !stop_wr)
        |=> chan_busy && (cur_desc == $past(eng_link)) && irq);

    assert_chain_end_R5: assert property (@(posedge clk) disable iff (rst)
        (chan_busy && eng_adv && (eng_link == '0)) |=> !chan_busy && irq);

    assert_append_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (append_q && en_q && !chan_busy && !ctrl_wr) |=> chan_busy && !append_q);

    assert_stop_R7: assert property (@(posedge clk) disable iff (rst)
        stop_wr |=> !chan_busy && !append_q);

    assert_busy_read_R9: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && (reg_addr == AW'(OFS_STAT))) |-> (reg_rdata[ST_BUSY] == chan_busy));

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (|eng_err) |=> irq);

endmodule

bind dma_chan_regs dma_chan_regs_chk #(.DW(DW), .AW(AW), .NE(NE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .eng_adv   (eng_adv),
    .eng_link  (eng_link),
    .eng_err   (eng_err),
    .fetch_go  (fetch_go),
    .cur_desc  (cur_desc),
    .chan_busy (chan_busy),
    .irq       (irq),
    .next_desc (next_q),
    .append_q  (ctrl.append),
    .en_q      (ctrl.en)
);

// File: tb/dma_chan_regs_bench.sv
module dma_chan_regs_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_rdata;
    logic        eng_adv = 1'b0;
    logic [31:0] eng_link = '0;
    logic [3:0]  eng_err = '0;
    logic        fetch_go;
    logic [31:0] cur_desc;
    logic        chan_busy;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    logic seen_fetch;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan_regs u_dma_chan_regs (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .eng_adv(eng_adv), .eng_link(eng_link), .eng_err(eng_err),
        .fetch_go(fetch_go), .cur_desc(cur_desc), .chan_busy(chan_busy), .irq(irq)
    );

    function automatic logic [31:0] err_word(input logic [3:0] e);
        logic [31:0] w = '0;
        w[1] = e[0];
        w[2] = e[1];
        w[3] = e[2];
        w[5] = e[3];
        return w;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        #1 seen_fetch = fetch_go;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        reg_rd   = 1'b1;
        #1 d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic adv(input logic [31:0] l);
        eng_adv  = 1'b1;
        eng_link = l;
        @(negedge clk);
        eng_adv = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [31:0] exp_st;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, d); check("R1 ctrl", d, 0);
        rd(8'h04, d); check("R1 stat", d, 0);
        rd(8'h0C, d); check("R1 cur", d, 0);
        rd(8'h10, d); check("R1 next", d, 0);
        check("R1 busy/irq", {chan_busy, irq}, 0);

        // R2 register access
        wr(8'h10, 32'h0000_1000);
        rd(8'h10, d); check("R2 next rw", d, 32'h1000);
        wr(8'h0C, 32'hDEAD_BEEF);
        rd(8'h0C, d); check("R2 cur ro", d, 0);
        rd(8'h08, d); check("R2 unmapped", d, 0);

        // R3 start
        wr(8'h00, 32'h1);
        check("R3 fetch_go", seen_fetch, 1);
        check("R3 busy", chan_busy, 1);
        rd(8'h0C, d); check("R3 cur", d, 32'h1000);
        rd(8'h04, d); check("R3 stat busy", d, 32'h400);

        // R4 advance with link
        adv(32'h2000);
        check("R4 cur", cur_desc, 32'h2000);
        rd(8'h04, d); check("R4 stat eot", d, 32'h600);
        check("R4 irq", irq, 1);

        // R9 clear eot, busy bit untouched
        wr(8'h04, 32'h0000_0600);
        rd(8'h04, d); check("R9 clear", d, 32'h400);
        check("R11 irq low", irq, 0);

        // R6 append pending while busy
        wr(8'h10, 32'h3000);
        wr(8'h00, 32'h3);
        rd(8'h00, d); check("R6 pending", d, 3);
        check("R6 cur held", cur_desc, 32'h2000);

        // R5 chain end then R6 refetch
        adv(32'h0);
        check("R5 not busy", chan_busy, 0);
        rd(8'h04, d); check("R5 stat", d, 32'h300);
        @(negedge clk);
        check("R6 busy again", chan_busy, 1);
        check("R6 cur", cur_desc, 32'h3000);
        rd(8'h00, d); check("R6 self clear", d, 1);

        // R7 stop with pending append
        wr(8'h00, 32'h3);
        wr(8'h00, 32'h0);
        check("R7 stopped", chan_busy, 0);
        rd(8'h00, d); check("R7 append dropped", d, 0);
        wr(8'h00, 32'h2);
        repeat (2) @(negedge clk);
        check("R7 append while off", {31'd0, chan_busy}, 0);
        rd(8'h00, d); check("R7 ctrl off", d, 0);

        // R10 set wins over clear
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, d); check("R9 clear all", d, 0);
        eng_err = 4'b0001;
        wr(8'h04, 32'h0000_0002);
        eng_err = 4'b0000;
        rd(8'h04, d); check("R10 set wins", d, 32'h2);
        wr(8'h04, 32'h2);

        // R8/R9/R11 random events with concurrent clears
        exp_st = 0;
        for (int i = 0; i < 200; i++) begin
            logic [3:0]  e;
            logic [31:0] m;
            e = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 2) != 0) e = 4'b0;
            m = $urandom;
            eng_err = e;
            wr(8'h04, m);
            eng_err = 4'b0;
            exp_st = (exp_st & ~m) | err_word(e);
            rd(8'h04, d); check("R8 random flags", d, exp_st);
            check("R11 irq", {31'd0, irq}, {31'd0, |exp_st});
        end

        // R6 append in the enabling write is dropped
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h10, 32'h4000);
        wr(8'h00, 32'h3);
        rd(8'h00, d); check("R6 start drops append", d, 1);
        adv(32'h0);
        @(negedge clk);
        check("R6 no restart", chan_busy, 0);
        check("R6 cur kept", cur_desc, 32'h4000);

        finish_run();
    end

    initial seen_fetch = 0;
    initial begin : seed
        int unused;
        unused = $urandom(32'd12345);
    end

endmodule